// File: doc/BRIEF.md
# Link Control Register with Retrain Sequencing

This block holds the link control word of one switch port. Software reaches it over a small configuration bus: a write strobe, an address, a function index, byte enables and write data, with read data returned combinationally for the addressed function. Each function of a multi-function port keeps its own power-management entry field. The port as a whole enables a power-management state only when every function enables it. A downstream port also keeps a link-disable bit.

The retrain bit in the write data is never stored. It works only as a trigger. When accepted, it produces a single-cycle pulse toward the link training state machine, and that pulse always comes after the write has been acknowledged. On an upstream port the trigger is honoured only while an external unlock input is high, and the pulse is then postponed by a programmable number of cycles. If a trigger arrives while training is already running, the power-management value presented to the training machine is frozen. It catches up with the register contents at the next retrain pulse.

Top module: `link_ctl_reg`

## Requirements
- R1: Bits 1:0 of each function's word hold the power-management entry enable, encoded 0 = none, 1 = L0s entry, 2 = L1 entry, 3 = both. They reset to 0 and read back for the function selected by `cfg_func` when `cfg_addr` equals the register address. Any other address reads 0.
- R2: `pm_enable` is the bitwise AND of the entry fields of all functions, unless it is frozen under R10.
- R3: Read data bits 2, 3, 5 and 31:6 are always 0. Bit 5 is the retrain trigger.
- R4: On a downstream port, bit 4 is the link-disable bit. A write to it appears in readback and on `link_disable` from the next cycle on. On an upstream port, bit 4 reads 0, writes to it are ignored, and `link_disable` stays 0.
- R5: `cfg_ack` is high in exactly the cycle after each cycle with `cfg_wr` high.
- R6: On a downstream port, an accepted write with bit 5 set while `trn_busy` is low raises `rtrn_pulse` for one cycle. The pulse comes two cycles after the write cycle, which is the cycle after the acknowledge.
- R7: On an upstream port, a write with bit 5 set while `reg_unlock` is low produces no pulse and freezes nothing.
- R8: On an upstream port with `reg_unlock` high, the pulse comes 2 + D cycles after the write cycle. D is `rtrn_delay` sampled in the write cycle, and D = 0 gives the cycle after the acknowledge.
- R9: A trigger that arrives while an earlier pulse is still pending is merged into it. There is no second pulse, and the pending timing is unchanged.
- R10: A trigger accepted while `trn_busy` is high gives no pulse. It freezes `pm_enable` at the value it had before that write. The freeze ends with the cycle after the next retrain pulse.
- R11: A write may set bit 5 and change the other fields in the same access. The field changes take effect just as in a write without the trigger.
- R12: A write takes effect only when the address matches and byte enable 0 is set. Any other write changes no field and triggers nothing, though it is still acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Write strobe, one cycle per access |
| cfg_addr | input | ADDR_W | Configuration address |
| cfg_func | input | FUNC_W | Function index of the access |
| cfg_be | input | 4 | Byte enables; only byte 0 carries fields |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for the addressed function |
| cfg_ack | output | 1 | Write acknowledge, one cycle after the write |
| reg_unlock | input | 1 | Retrain unlock control (upstream variant only) |
| rtrn_delay | input | DLY_W | Retrain delay in cycles (upstream variant only) |
| trn_busy | input | 1 | Training machine already in Recovery or Configuration |
| pm_enable | output | 2 | Effective port power-management entry enables |
| link_disable | output | 1 | Link-disable request |
| rtrn_pulse | output | 1 | Single-cycle retrain request to the training machine |

## Verification
The bench builds two copies side by side and drives them with the same bus traffic. One is a downstream port with three functions, which exercises link disable, the immediate retrain and an AND over an odd number of functions. The other is an upstream port with two functions, which exercises the unlock gate, delays of zero and three cycles, and the merge of a trigger into a pending delayed pulse. Together they cover the freeze of the power-management output when a trigger lands during training, on both variants.

// File: rtl/lnk_pkg.sv
`timescale 1ns/1ps
package lnk_pkg;

    localparam int DATA_W   = 32;
    localparam int PM_LSB   = 0;
    localparam int PM_W     = 2;
    localparam int LDIS_BIT = 4;
    localparam int RTRN_BIT = 5;

    typedef logic [PM_W-1:0] pm_en_t;

    typedef enum logic [1:0] {
        SQ_IDLE    = 2'd0,
        SQ_ACKWAIT = 2'd1,
        SQ_COUNT   = 2'd2
    } sq_phase_e;

    typedef struct packed {
        pm_en_t pm;
        logic   ldis;
        logic   rtrn;
    } lnk_wr_t;

    function automatic lnk_wr_t lnk_decode(input logic [DATA_W-1:0] d);
        lnk_wr_t w;
        w.pm   = d[PM_LSB +: PM_W];
        w.ldis = d[LDIS_BIT];
        w.rtrn = d[RTRN_BIT];
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] lnk_encode(input pm_en_t pm, input logic ldis);
        logic [DATA_W-1:0] d;
        d = '0;
        d[PM_LSB +: PM_W] = pm;
        d[LDIS_BIT]       = ldis;
        return d;
    endfunction

endpackage

// File: rtl/lnk_fields.sv
`timescale 1ns/1ps
module lnk_fields import lnk_pkg::*; #(
    parameter bit IS_DOWNSTREAM = 1'b1,
    parameter int NUM_FUNC      = 2,
    parameter int FUNC_W        = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [FUNC_W-1:0] func,
    input  lnk_wr_t           wr,
    output logic [DATA_W-1:0] rd_data,
    output pm_en_t            pm_live,
    output logic              ldis_q
);
    localparam int FLAT_W = NUM_FUNC * PM_W;

    logic [FLAT_W-1:0] pm_flat;

    for (genvar g = 0; g < NUM_FUNC; g++) begin : g_func
        pm_en_t pm_r;
        always_ff @(posedge clk) begin
            if (rst)
                pm_r <= '0;
            else if (wr_en && func == FUNC_W'(g))
                pm_r <= wr.pm;
        end
        assign pm_flat[g*PM_W +: PM_W] = pm_r;
    end

    if (IS_DOWNSTREAM) begin : g_ldis
        always_ff @(posedge clk) begin
            if (rst)
                ldis_q <= 1'b0;
            else if (wr_en)
                ldis_q <= wr.ldis;
        end

        AST_LDIS_TRACKS_WRITE: assert property (@(posedge clk) disable iff (rst)
            wr_en |=> (ldis_q == $past(wr.ldis))); // R4
    end else begin : g_no_ldis
        assign ldis_q = 1'b0;
        logic unused_ldis;
        assign unused_ldis = wr.ldis;
    end

    always_comb begin
        pm_live = '1;
        for (int i = 0; i < NUM_FUNC; i++)
            pm_live &= pm_flat[i*PM_W +: PM_W];
    end

    always_comb begin
        pm_en_t sel;
        sel = '0;
        for (int i = 0; i < NUM_FUNC; i++)
            if (func == FUNC_W'(i))
                sel = pm_flat[i*PM_W +: PM_W];
        rd_data = lnk_encode(sel, ldis_q);
    end

    logic unused_rtrn;
    assign unused_rtrn = wr.rtrn;

endmodule

// File: rtl/lnk_rtrn_seq.sv
`timescale 1ns/1ps
module lnk_rtrn_seq import lnk_pkg::*; #(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic [DLY_W-1:0] dly,
    output logic             pulse
);
    sq_phase_e        phase;
    logic [DLY_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= SQ_IDLE;
            cnt   <= '0;
        end else begin
            unique case (phase)
                SQ_IDLE: begin
                    if (req) begin
                        phase <= SQ_ACKWAIT;
                        cnt   <= dly;
                    end
                end
                SQ_ACKWAIT: phase <= SQ_COUNT;
                SQ_COUNT: begin
                    if (cnt == '0)
                        phase <= SQ_IDLE;
                    else
                        cnt <= cnt - DLY_W'(1);
                end
                default: phase <= SQ_IDLE;
            endcase
        end
    end

    assign pulse = (phase == SQ_COUNT) && (cnt == '0);

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        pulse |=> !pulse); // R6
    AST_NO_PULSE_AT_ACK: assert property (@(posedge clk) disable iff (rst)
        (req && phase == SQ_IDLE) |=> !pulse); // R8
    AST_COUNT_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
        (phase == SQ_COUNT && cnt != '0) |=> (cnt == $past(cnt) - DLY_W'(1))); // R9

endmodule

// File: rtl/lnk_apply.sv
`timescale 1ns/1ps
module lnk_apply import lnk_pkg::*; (
    input  logic   clk,
    input  logic   rst,
    input  pm_en_t pm_live,
    input  logic   hold_set,
    input  logic   pulse,
    output pm_en_t pm_out
);
    logic   hold_q;
    pm_en_t applied_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q    <= 1'b0;
            applied_q <= '0;
        end else begin
            if (!hold_q)
                applied_q <= pm_live;
            if (hold_set)
                hold_q <= 1'b1;
            else if (pulse)
                hold_q <= 1'b0;
        end
    end

    assign pm_out = hold_q ? applied_q : pm_live;

    AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (hold_q && $past(hold_q)) |-> $stable(pm_out)); // R10

endmodule

// File: rtl/link_ctl_reg.sv
`timescale 1ns/1ps
module link_ctl_reg import lnk_pkg::*; #(
    parameter bit                IS_DOWNSTREAM = 1'b1,
    parameter int                NUM_FUNC      = 2,
    parameter int                FUNC_W        = (NUM_FUNC > 1) ? $clog2(NUM_FUNC) : 1,
    parameter int                ADDR_W        = 12,
    parameter logic [ADDR_W-1:0] REG_ADDR      = 'h0A0,
    parameter int                DLY_W         = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [FUNC_W-1:0] cfg_func,
    input  logic [3:0]        cfg_be,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    output logic              cfg_ack,
    input  logic              reg_unlock,
    input  logic [DLY_W-1:0]  rtrn_delay,
    input  logic              trn_busy,
    output logic [1:0]        pm_enable,
    output logic              link_disable,
    output logic              rtrn_pulse
);
    logic              addr_hit;
    logic              wr_hit;
    lnk_wr_t           wr_f;
    logic              rtrn_allow;
    logic              rtrn_ok;
    logic              seq_req;
    logic              hold_set;
    logic [DLY_W-1:0]  seq_dly;
    logic [DATA_W-1:0] fld_rd;
    pm_en_t            pm_live;

    assign addr_hit = (cfg_addr == REG_ADDR);
    assign wr_hit   = cfg_wr && addr_hit && cfg_be[0];
    assign wr_f     = lnk_decode(cfg_wdata);

    if (IS_DOWNSTREAM) begin : g_dn
        assign rtrn_allow = 1'b1;
        assign seq_dly    = '0;
    end else begin : g_up
        assign rtrn_allow = reg_unlock;
        assign seq_dly    = rtrn_delay;
    end

    assign rtrn_ok  = wr_hit && wr_f.rtrn && rtrn_allow;
    assign seq_req  = rtrn_ok && !trn_busy;
    assign hold_set = rtrn_ok && trn_busy;

    always_ff @(posedge clk) begin
        if (rst)
            cfg_ack <= 1'b0;
        else
            cfg_ack <= cfg_wr;
    end

    lnk_fields #(
        .IS_DOWNSTREAM (IS_DOWNSTREAM),
        .NUM_FUNC      (NUM_FUNC),
        .FUNC_W        (FUNC_W)
    ) u_fields (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_hit),
        .func    (cfg_func),
        .wr      (wr_f),
        .rd_data (fld_rd),
        .pm_live (pm_live),
        .ldis_q  (link_disable)
    );

    lnk_rtrn_seq #(.DLY_W(DLY_W)) u_seq (
        .clk   (clk),
        .rst   (rst),
        .req   (seq_req),
        .dly   (seq_dly),
        .pulse (rtrn_pulse)
    );

    lnk_apply u_apply (
        .clk      (clk),
        .rst      (rst),
        .pm_live  (pm_live),
        .hold_set (hold_set),
        .pulse    (rtrn_pulse),
        .pm_out   (pm_enable)
    );

    assign cfg_rdata = addr_hit ? fld_rd : '0;

    logic unused_in;
    assign unused_in = ^{cfg_be[3:1], cfg_wdata[31:6], cfg_wdata[3:2], rtrn_delay, reg_unlock};

    AST_ACK_FOLLOWS_WR: assert property (@(posedge clk) disable iff (rst)
        cfg_wr |=> cfg_ack); // R5
    AST_ACK_ONLY_AFTER_WR: assert property (@(posedge clk) disable iff (rst)
        !cfg_wr |=> !cfg_ack); // R5

endmodule

// File: tb/sim_link_ctl_reg.sv
`timescale 1ns/1ps
module ref_lnk #(
    parameter bit       DOWN = 1'b1,
    parameter int       NF   = 2,
    parameter int       FW   = 1,
    parameter int       DW   = 8,
    parameter bit [7:0] RA   = 8'h40
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic [7:0]    addr,
    input  logic [FW-1:0] func,
    input  logic [3:0]    be,
    input  logic [31:0]   wd,
    input  logic          unlock,
    input  logic [DW-1:0] dly,
    input  logic          busy,
    output logic [31:0]   e_rd,
    output logic          e_ack,
    output logic          e_pulse,
    output logic [1:0]    e_pm,
    output logic          e_ldis
);
    int pm [NF];
    int ldis, cyc, sched, hold, held, ack;

    function automatic int all_and();
        int a;
        a = 3;
        for (int i = 0; i < NF; i++) a = a & pm[i];
        return a;
    endfunction

    always @(posedge clk) begin
        bit hit, req, pulsing;
        int old;
        if (rst) begin
            for (int i = 0; i < NF; i++) pm[i] = 0;
            ldis = 0; sched = -1; hold = 0; held = 0; ack = 0; cyc = 0;
        end else begin
            pulsing = (cyc == sched);
            old     = all_and();
            hit     = wr && (addr == RA) && be[0];
            if (hit && int'(func) < NF) pm[int'(func)] = int'(wd[1:0]);
            if (hit && DOWN) ldis = int'(wd[4]);
            req = hit && wd[5] && (DOWN || unlock);
            if (req && busy) begin
                if (hold == 0) held = old;
                hold = 1;
            end else if (req && sched < 0) begin
                sched = cyc + 2 + (DOWN ? 0 : int'(dly));
            end
            if (pulsing) begin
                sched = -1;
                if (!(req && busy)) hold = 0;
            end
            ack = int'(wr);
            cyc++;
        end
    end

    always_comb begin
        int s;
        s = 0;
        if (int'(func) < NF) s = pm[int'(func)];
        e_rd    = (addr == RA) ? ((32'(s) & 32'h3) | (32'(ldis) << 4)) : 32'h0;
        e_ack   = (ack != 0);
        e_pulse = (cyc == sched);
        e_pm    = (hold != 0) ? 2'(held) : 2'(all_and());
        e_ldis  = (ldis != 0);
    end
endmodule

module sim_link_ctl_reg;
    localparam logic [7:0] REG = 8'h40;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_addr = REG;
    logic [1:0]  cfg_func = 2'd0;
    logic [3:0]  cfg_be = 4'h0;
    logic [31:0] cfg_wdata = 32'h0;
    logic        reg_unlock = 1'b0;
    logic [7:0]  rtrn_delay = 8'd0;
    logic        trn_busy = 1'b0;

    logic [31:0] rd0, rd1, erd0, erd1;
    logic        ack0, ack1, eack0, eack1;
    logic        pl0, pl1, epl0, epl1;
    logic [1:0]  pm0, pm1, epm0, epm1;
    logic        ld0, ld1, eld0, eld1;

    int checks = 0;
    int errors = 0;
    int up_pulses = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    link_ctl_reg #(.IS_DOWNSTREAM(1'b1), .NUM_FUNC(3), .ADDR_W(8), .REG_ADDR(REG), .DLY_W(8)) u0 (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_func(cfg_func),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(rd0), .cfg_ack(ack0),
        .reg_unlock(reg_unlock), .rtrn_delay(rtrn_delay), .trn_busy(trn_busy),
        .pm_enable(pm0), .link_disable(ld0), .rtrn_pulse(pl0));

    link_ctl_reg #(.IS_DOWNSTREAM(1'b0), .NUM_FUNC(2), .ADDR_W(8), .REG_ADDR(REG), .DLY_W(8)) u1 (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_func(cfg_func[0:0]),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(rd1), .cfg_ack(ack1),
        .reg_unlock(reg_unlock), .rtrn_delay(rtrn_delay), .trn_busy(trn_busy),
        .pm_enable(pm1), .link_disable(ld1), .rtrn_pulse(pl1));

    ref_lnk #(.DOWN(1'b1), .NF(3), .FW(2), .DW(8), .RA(REG)) m0 (
        .clk(clk), .rst(rst), .wr(cfg_wr), .addr(cfg_addr), .func(cfg_func), .be(cfg_be),
        .wd(cfg_wdata), .unlock(reg_unlock), .dly(rtrn_delay), .busy(trn_busy),
        .e_rd(erd0), .e_ack(eack0), .e_pulse(epl0), .e_pm(epm0), .e_ldis(eld0));

    ref_lnk #(.DOWN(1'b0), .NF(2), .FW(1), .DW(8), .RA(REG)) m1 (
        .clk(clk), .rst(rst), .wr(cfg_wr), .addr(cfg_addr), .func(cfg_func[0:0]), .be(cfg_be),
        .wd(cfg_wdata), .unlock(reg_unlock), .dly(rtrn_delay), .busy(trn_busy),
        .e_rd(erd1), .e_ack(eack1), .e_pulse(epl1), .e_pm(epm1), .e_ldis(eld1));

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Model comparison on every clock, after the edge has settled
    always @(posedge clk) begin
        #1;
        if (!rst && !done) begin
            check("R1 down rdata", int'(rd0), int'(erd0));
            check("R5 down ack", int'(ack0), int'(eack0));
            check("R6 down pulse", int'(pl0), int'(epl0));
            check("R2 down pm_enable", int'(pm0), int'(epm0));
            check("R4 down link_disable", int'(ld0), int'(eld0));
            check("R3 up rdata", int'(rd1), int'(erd1));
            check("R5 up ack", int'(ack1), int'(eack1));
            check("R8 up pulse", int'(pl1), int'(epl1));
            check("R10 up pm_enable", int'(pm1), int'(epm1));
            check("R4 up link_disable", int'(ld1), int'(eld1));
            if (pl1) up_pulses++;
        end
    end

    task automatic do_wr(input logic [7:0] a, input logic [1:0] f, input logic [3:0] b, input logic [31:0] d);
        cfg_wr = 1'b1; cfg_addr = a; cfg_func = f; cfg_be = b; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_addr = REG; cfg_func = 2'd0; cfg_be = 4'h0; cfg_wdata = 32'h0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        int base;
        idle(3);
        rst = 1'b0;
        idle(1);
        check("R1 reset rdata down", int'(rd0), 0);
        check("R1 reset rdata up", int'(rd1), 0);
        check("R6 reset pulse", int'(pl0), 0);

        // per-function fields and AND combination
        do_wr(REG, 2'd0, 4'hF, 32'h3);
        do_wr(REG, 2'd1, 4'hF, 32'h1);
        do_wr(REG, 2'd2, 4'hF, 32'h3);
        check("R2 and of 3,1,3", int'(pm0), 1);
        cfg_func = 2'd1; #1;
        check("R1 readback func1", int'(rd0), 1);
        cfg_func = 2'd0;

        // reserved bits, link disable
        do_wr(REG, 2'd0, 4'hF, 32'hFFFF_FFDF);
        check("R3 R4 down rdata", int'(rd0), 32'h13);
        check("R4 down link_disable", int'(ld0), 1);
        check("R4 up rdata ignores bit4", int'(rd1), 32'h03);
        check("R4 up link_disable zero", int'(ld1), 0);

        // misses: wrong address, byte enable 0 clear
        do_wr(REG + 8'd1, 2'd0, 4'hF, 32'h0);
        do_wr(REG, 2'd0, 4'hE, 32'h0);
        check("R12 fields unchanged", int'(rd0), 32'h13);
        cfg_addr = REG + 8'd1; #1;
        check("R1 other address reads zero", int'(rd0), 0);
        cfg_addr = REG;

        // downstream immediate retrain with field change, upstream locked
        base = up_pulses;
        do_wr(REG, 2'd0, 4'hF, 32'h22);
        check("R6 no pulse in ack cycle", int'(pl0), 0);
        check("R5 ack after write", int'(ack0), 1);
        idle(1);
        check("R6 pulse after ack", int'(pl0), 1);
        check("R11 fields changed with trigger", int'(rd0), 32'h02);
        check("R3 retrain bit reads zero", int'(rd0[5]), 0);
        idle(1);
        check("R6 pulse single cycle", int'(pl0), 0);
        idle(8);
        check("R7 locked upstream no pulse", up_pulses - base, 0);

        // upstream unlocked, delay 3
        reg_unlock = 1'b1;
        rtrn_delay = 8'd3;
        do_wr(REG, 2'd0, 4'hF, 32'h22);
        for (int k = 1; k <= 4; k++) begin
            idle(1);
            check("R8 delayed pulse timing", int'(pl1), (k == 4) ? 1 : 0);
        end
        idle(6);

        // merge of a second trigger into the pending one
        base = up_pulses;
        do_wr(REG, 2'd0, 4'hF, 32'h22);
        idle(1);
        do_wr(REG, 2'd0, 4'hF, 32'h22);
        idle(12);
        check("R9 merged single pulse", up_pulses - base, 1);

        // zero delay
        rtrn_delay = 8'd0;
        do_wr(REG, 2'd0, 4'hF, 32'h22);
        idle(1);
        check("R8 zero delay pulse", int'(pl1), 1);
        idle(6);

        // freeze during training
        do_wr(REG, 2'd1, 4'hF, 32'h3);
        check("R2 and of 2,3,3", int'(pm0), 2);
        trn_busy = 1'b1;
        do_wr(REG, 2'd0, 4'hF, 32'h21);
        trn_busy = 1'b0;
        idle(5);
        check("R10 pm frozen down", int'(pm0), 2);
        check("R10 pm frozen up", int'(pm1), 2);
        check("R10 no pulse while busy", int'(pl0), 0);
        check("R1 readback not frozen", int'(rd0), 1);
        do_wr(REG, 2'd0, 4'hF, 32'h21);
        idle(1);
        check("R10 pulse ends freeze", int'(pl0), 1);
        check("R10 still frozen on pulse", int'(pm0), 2);
        idle(1);
        check("R10 released after pulse", int'(pm0), 1);
        idle(5);
        finish_run();
    end

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete actual=hung expected=done");
            finish_run();
        end
    end
endmodule